// File: doc/BRIEF.md
# Flash Write-Protection Status Controller

This block holds the protection state of a 512 KB serial flash and rules on every modifying request made to the array. The state is a two-bit protection level and a freeze bit. The level selects how much of the address space, counted down from the top, is shielded from program and erase. The freeze bit works together with the write-protect pin: when the pin is low and the freeze bit is set, the protection state cannot be changed.

Each request arrives as a one-cycle strobe that carries an operation code, a 19-bit byte address and three bits of status data. On the next clock edge the block raises exactly one of a grant or a deny flag for one cycle. For program and sector-erase requests it also reports which of the twelve sectors the address falls in. The sectors are not all the same size: the bottom seven are 64 KB, and the top 64 KB is split into pieces of 32, 16, 4, 4 and 8 KB. Serial framing and the actual array access are handled by the surrounding logic.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset the protection level is 3 (`prot_o`=11), `lock_o` is 0, `grant_o` and `deny_o` are 0 and `sector_o` is 0.
- R2: A program request (`req_op_i`=00) is refused when its address is at or above the protection floor and granted otherwise. The floor is 80000h (nothing protected) for level 0, 70000h for level 1, 60000h for level 2 and 00000h (the whole array) for level 3.
- R3: A chip-erase request (`req_op_i`=10) is granted if and only if the protection level is 0, whatever the pin and the freeze bit are.
- R4: A sector-erase request (`req_op_i`=01) is judged on the start address of the sector that holds `req_addr_i`. It is refused when any part of that sector lies at or above the floor.
- R5: A status write (`req_op_i`=11) made while `wp_pin_i` is high or `lock_o` is 0 is granted. On the strobe edge it loads the level from `req_wdata_i[1:0]` and the freeze bit from `req_wdata_i[2]`, and the new values appear on `prot_o` and `lock_o` in the following cycle.
- R6: A status write made while `wp_pin_i` is low and `lock_o` is 1 is refused and leaves `prot_o` and `lock_o` unchanged.
- R7: While `wp_pin_i` is high, a set freeze bit does not block a status write.
- R8: `sector_o` gives the sector index of a program or sector-erase address. For addresses below 70000h it is the address divided by 64 KB (sectors 0 to 6). Above that: sector 7 is 70000h–77FFFh, 8 is 78000h–7BFFFh, 9 is 7C000h–7CFFFh, 10 is 7D000h–7DFFFh and 11 is 7E000h–7FFFFh. Other requests leave `sector_o` unchanged.
- R9: `grant_o` or `deny_o` (never both) is high for exactly the one cycle after each request strobe, and both are low after a cycle with no strobe. A refused request changes no protection state, and the state changes only through a granted status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wp_pin_i | input | 1 | Write-protect pin level, 1 = high |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_op_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 status write |
| req_addr_i | input | 19 | Byte address for program or sector erase |
| req_wdata_i | input | 3 | Status data: [1:0] level, [2] freeze bit |
| grant_o | output | 1 | Request accepted, one-cycle pulse |
| deny_o | output | 1 | Request refused, one-cycle pulse |
| sector_o | output | 4 | Sector index of the last program or sector-erase address |
| prot_o | output | 2 | Current protection level |
| lock_o | output | 1 | Current freeze bit |

## Verification
Two things can meet on one clock edge. One is a status-write strobe arriving while the write-protect pin toggles in the same cycle. The other is an array request issued in the cycle right after a status write, which must be judged against the newly loaded level rather than the old one. The bench provokes both by driving back-to-back strobes and by flipping `wp_pin_i` in the same cycle as status writes. A behavioural reference model uses the pin and state values present at each strobe edge and compares all outputs on every clock.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam int FWP_ADDR_W = 19;
    localparam int FWP_SEC_W  = 4;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_WRSTAT = 2'b11
    } fwp_op_e;

    typedef struct packed {
        logic [1:0]           level;
        logic                 lock;
        logic                 grant;
        logic                 deny;
        logic [FWP_SEC_W-1:0] sector;
    } fwp_state_t;

    // lowest protected byte address; one bit wider so "nothing" is representable
    function automatic logic [FWP_ADDR_W:0] prot_floor(input logic [1:0] level);
        case (level)
            2'd0:    prot_floor = 20'h80000;
            2'd1:    prot_floor = 20'h70000;
            2'd2:    prot_floor = 20'h60000;
            default: prot_floor = 20'h00000;
        endcase
    endfunction

    function automatic logic [FWP_ADDR_W-1:0] sector_base(input logic [FWP_SEC_W-1:0] idx);
        if (idx < 4'd7) begin
            sector_base = {idx[2:0], 16'h0000};
        end else begin
            case (idx)
                4'd7:    sector_base = 19'h70000;
                4'd8:    sector_base = 19'h78000;
                4'd9:    sector_base = 19'h7C000;
                4'd10:   sector_base = 19'h7D000;
                default: sector_base = 19'h7E000;
            endcase
        end
    endfunction

endpackage

// File: rtl/fwp_sector_map.sv
module fwp_sector_map
    import fwp_pkg::*;
#(
    parameter int ADDR_W = FWP_ADDR_W,
    parameter int SEC_W  = FWP_SEC_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SEC_W-1:0]  sector_o
);
    localparam int HI = ADDR_W - 1;

    logic [2:0] big_idx;
    assign big_idx = addr_i[HI -: 3];

    always_comb begin
        if (big_idx != 3'b111) begin
            sector_o = SEC_W'(big_idx);
        end else if (!addr_i[HI-3]) begin
            sector_o = SEC_W'(7);
        end else if (!addr_i[HI-4]) begin
            sector_o = SEC_W'(8);
        end else if (!addr_i[HI-5]) begin
            sector_o = addr_i[HI-6] ? SEC_W'(10) : SEC_W'(9);
        end else begin
            sector_o = SEC_W'(11);
        end
    end
endmodule

// File: rtl/fwp_region_check.sv
module fwp_region_check
    import fwp_pkg::*;
#(
    parameter int ADDR_W = FWP_ADDR_W,
    parameter int SEC_W  = FWP_SEC_W
) (
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEC_W-1:0]  sector_i,
    input  logic [1:0]        level_i,
    output logic              array_ok_o
);
    logic [ADDR_W-1:0] probe;
    logic [ADDR_W:0]   floor_addr;

    assign floor_addr = prot_floor(level_i);

    always_comb begin
        // a sector erase is judged on the first byte of its sector
        probe = (fwp_op_e'(op_i) == OP_SERASE) ? sector_base(sector_i) : addr_i;
        case (fwp_op_e'(op_i))
            OP_CERASE: array_ok_o = (level_i == 2'd0);
            OP_WRSTAT: array_ok_o = 1'b0;
            default:   array_ok_o = ({1'b0, probe} < floor_addr);
        endcase
    end
endmodule

// File: rtl/fwp_status_gate.sv
module fwp_status_gate (
    input  logic wp_pin_i,
    input  logic lock_i,
    output logic wr_ok_o
);
    // the freeze bit only matters while the pin is held low
    assign wr_ok_o = wp_pin_i | ~lock_i;
endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
    import fwp_pkg::*;
#(
    parameter int ADDR_W = FWP_ADDR_W,
    parameter int SEC_W  = FWP_SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [2:0]        req_wdata_i,
    output logic              grant_o,
    output logic              deny_o,
    output logic [SEC_W-1:0]  sector_o,
    output logic [1:0]        prot_o,
    output logic              lock_o
);
    fwp_state_t st_d, st_q;
    logic [SEC_W-1:0] req_sector;
    logic             array_ok;
    logic             wr_ok;

    fwp_sector_map #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_map (
        .addr_i   (req_addr_i),
        .sector_o (req_sector)
    );

    fwp_region_check #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_region (
        .op_i       (req_op_i),
        .addr_i     (req_addr_i),
        .sector_i   (req_sector),
        .level_i    (st_q.level),
        .array_ok_o (array_ok)
    );

    fwp_status_gate u_gate (
        .wp_pin_i (wp_pin_i),
        .lock_i   (st_q.lock),
        .wr_ok_o  (wr_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.deny  = 1'b0;
        if (req_valid_i) begin
            case (fwp_op_e'(req_op_i))
                OP_WRSTAT: begin
                    if (wr_ok) begin
                        st_d.level = req_wdata_i[1:0];
                        st_d.lock  = req_wdata_i[2];
                        st_d.grant = 1'b1;
                    end else begin
                        st_d.deny  = 1'b1;
                    end
                end
                OP_CERASE: begin
                    st_d.grant = array_ok;
                    st_d.deny  = ~array_ok;
                end
                default: begin
                    st_d.sector = req_sector;
                    st_d.grant  = array_ok;
                    st_d.deny   = ~array_ok;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level  <= 2'b11;
            st_q.lock   <= 1'b0;
            st_q.grant  <= 1'b0;
            st_q.deny   <= 1'b0;
            st_q.sector <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o  = st_q.grant;
    assign deny_o   = st_q.deny;
    assign sector_o = st_q.sector;
    assign prot_o   = st_q.level;
    assign lock_o   = st_q.lock;
endmodule

// File: rtl/fwp_guard_checker.sv
module fwp_guard_checker #(
    parameter int ADDR_W = 19,
    parameter int SEC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_pin_i,
    input logic              req_valid_i,
    input logic [1:0]        req_op_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              grant_o,
    input logic              deny_o,
    input logic [1:0]        prot_o,
    input logic              lock_o
);
    // R9: one verdict at most
    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    // R9: quiet after a cycle without a strobe
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!grant_o && !deny_o));

    // R9: protection state moves only on a status write strobe
    p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && req_op_i == 2'b11) |=> ($stable(prot_o) && $stable(lock_o)));

    // R6: frozen status refuses writes
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'b11 && !wp_pin_i && lock_o)
        |=> (deny_o && $stable(prot_o) && $stable(lock_o)));

    // R7: pin high always admits status writes
    p_pin_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'b11 && wp_pin_i) |=> grant_o);

    // R3: chip erase needs level 0
    p_chip_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'b10) |=> (grant_o == ($past(prot_o) == 2'b00)));

    // R2: full protection refuses every program
    p_full_prot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'b00 && prot_o == 2'b11) |=> deny_o);
endmodule

bind flash_guard_ctrl fwp_guard_checker #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_pin_i    (wp_pin_i),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .grant_o     (grant_o),
    .deny_o      (deny_o),
    .prot_o      (prot_o),
    .lock_o      (lock_o)
);

// File: tb/flash_guard_ctrl_tb.sv
module flash_guard_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_pin_i = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_op_i = 2'b00;
    logic [18:0] req_addr_i = '0;
    logic [2:0]  req_wdata_i = '0;
    logic        grant_o, deny_o, lock_o;
    logic [3:0]  sector_o;
    logic [1:0]  prot_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // reference model state
    int m_level = 3, m_lock = 0, m_grant = 0, m_deny = 0, m_sector = 0;

    always #10 clk = ~clk;

    flash_guard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin_i), .req_valid_i(req_valid_i),
        .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .grant_o(grant_o), .deny_o(deny_o), .sector_o(sector_o),
        .prot_o(prot_o), .lock_o(lock_o)
    );

    function automatic int ref_floor(int lvl);
        case (lvl)
            0: return 'h80000;
            1: return 'h70000;
            2: return 'h60000;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_sector(int a);
        if (a < 'h70000) return a / 'h10000;
        if (a < 'h78000) return 7;
        if (a < 'h7C000) return 8;
        if (a < 'h7D000) return 9;
        if (a < 'h7E000) return 10;
        return 11;
    endfunction

    function automatic int ref_start(int s);
        int starts[12] = '{'h00000, 'h10000, 'h20000, 'h30000, 'h40000, 'h50000,
                           'h60000, 'h70000, 'h78000, 'h7C000, 'h7D000, 'h7E000};
        return starts[s];
    endfunction

    task automatic compare(string tag);
        vectors++;
        if (grant_o !== m_grant[0] || deny_o !== m_deny[0] || sector_o !== 4'(m_sector)
            || prot_o !== 2'(m_level) || lock_o !== m_lock[0]) begin
            misses++;
            $display("FAIL %s: got g=%0b d=%0b s=%0d p=%0d l=%0b exp g=%0d d=%0d s=%0d p=%0d l=%0d",
                     tag, grant_o, deny_o, sector_o, prot_o, lock_o,
                     m_grant, m_deny, m_sector, m_level, m_lock);
        end
    endtask

    // one clock: drive on negedge, model on posedge, compare shortly after
    task automatic step(bit v, int op, int addr, int wd, bit wp, string tag);
        int ok;
        @(negedge clk);
        req_valid_i = v; req_op_i = 2'(op); req_addr_i = 19'(addr);
        req_wdata_i = 3'(wd); wp_pin_i = wp;
        @(posedge clk);
        m_grant = 0; m_deny = 0;
        if (v) begin
            if (op == 3) begin
                ok = (wp || m_lock == 0);
                if (ok) begin m_level = wd & 3; m_lock = (wd >> 2) & 1; end
            end else if (op == 2) begin
                ok = (m_level == 0);
            end else begin
                m_sector = ref_sector(addr);
                ok = ((op == 1 ? ref_start(m_sector) : addr) < ref_floor(m_level));
            end
            m_grant = ok; m_deny = !ok;
        end
        #5;
        compare(tag);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 compare("R1 reset");
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, 1, "R1 after release");
        // level 3: everything refused
        step(1, 0, 'h00000, 0, 0, "R2 lvl3 program low");
        step(1, 0, 'h7FFFF, 0, 0, "R2 lvl3 program top");
        step(1, 2, 0, 0, 0, "R3 chip erase lvl3");
        step(1, 1, 'h12345, 0, 1, "R4 serase lvl3");
        // clear protection, pin low, freeze 0
        step(1, 3, 0, 3'b000, 0, "R5 write lvl0");
        step(1, 2, 0, 0, 0, "R3 chip erase lvl0 back-to-back");
        for (int a = 0; a < 'h80000; a += 'h1800)
            step(1, 0, a, 0, 1, "R8 sector sweep");
        step(1, 0, 'h7CFFF, 0, 1, "R8 sector 9 edge");
        step(1, 0, 'h7D000, 0, 1, "R8 sector 10 edge");
        step(1, 0, 'h7DFFF, 0, 1, "R8 sector 10 end");
        step(1, 0, 'h7E000, 0, 1, "R8 sector 11 start");
        step(1, 2, 0, 0, 1, "R8 chip erase keeps sector");
        // level 1
        step(1, 3, 0, 3'b001, 1, "R5 write lvl1");
        step(1, 0, 'h6FFFF, 0, 1, "R2 lvl1 below floor");
        step(1, 0, 'h70000, 0, 1, "R2 lvl1 at floor");
        step(1, 1, 'h6FFFF, 0, 1, "R4 serase sector6 lvl1");
        step(1, 1, 'h7E123, 0, 1, "R4 serase sector11 lvl1");
        step(1, 2, 0, 0, 1, "R3 chip erase lvl1");
        // level 2 with freeze, pin low in the same cycle
        step(1, 3, 0, 3'b110, 0, "R5 write lvl2 freeze");
        step(1, 1, 'h6ABCD, 0, 0, "R4 serase sector6 lvl2");
        step(1, 1, 'h5FFFF, 0, 0, "R4 serase sector5 lvl2");
        step(1, 3, 0, 3'b000, 0, "R6 frozen write refused");
        step(0, 0, 0, 0, 0, "R9 idle after deny");
        step(1, 3, 0, 3'b011, 0, "R6 frozen write refused again");
        step(1, 0, 'h5FFFF, 0, 0, "R2 lvl2 still holds");
        step(1, 0, 'h60000, 0, 0, "R2 lvl2 at floor");
        // pin rises in the cycle of the write
        step(1, 3, 0, 3'b100, 1, "R7 pin high overrides freeze");
        step(1, 2, 0, 0, 0, "R3 chip erase lvl0 with freeze");
        step(1, 3, 0, 3'b001, 0, "R6 lvl0 frozen write refused");
        step(1, 3, 0, 3'b011, 1, "R7 pin high write lvl3");
        step(1, 0, 'h00010, 0, 1, "R2 lvl3 program");
        step(0, 0, 0, 0, 1, "R9 idle");
        step(0, 0, 0, 0, 0, "R9 idle pin low");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule